// File: doc/BRIEF.md
# Multi-Channel Power Sequencer

This block orders the switch-on and switch-off of four step-down regulator channels. Each channel is placed in one of four ordered positions. On power-up the block walks the positions from the lowest to the highest. It raises the enable request of every channel in a position together. It then waits until all of them report that they are in regulation, lets a programmable gap elapse, and moves on to the next position. On power-down it walks the positions in reverse. A position is finished when its channels report that they have drained, or, when that check is turned off, as soon as its requests are dropped. A separate gap applies between positions on the way down.

The cascade is started by raising a request pin and reversed by lowering it. Software may switch any single channel on or off at any time, outside the cascade. A filtered trip input, and a power-up position that stays out of regulation too long, both end the run. A configuration bit selects whether the trip cascades down in order or clears every request at once. After a trip or a timeout the block stays off until the request pin has been lowered. A status word always shows the requests, the regulation flags, the current position and the phase.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset all channel requests are 0, the phase is off (code 0) and the sequence-error flag is 0.
- R2: With the request pin high and no lock, the block leaves the off phase and raises the requests of position 0 on the second clock edge after the pin is sampled high. Positions then start in rising order, and all channels of one position are raised on the same edge. The 2-bit position field of channel i sits at bits 2i+1:2i of the position-select input.
- R3: A position's requests rise only after every channel of the position before it is in regulation. They rise exactly up-gap + 1 edges after the edge at which the last such flag is first sampled high.
- R4: A position with no channels assigned is passed in one clock cycle, with no gap.
- R5: When every channel of the highest position is in regulation, the phase becomes on (code 4).
- R6: Lowering the request pin from the on phase clears the requests of position 3 on the second edge after the pin is sampled low. Positions are then cleared in falling order down to position 0, after which the phase is off.
- R7: On the way down, with the drain check enabled, the next lower position is cleared down-gap + 1 edges after all channels of the current position are first sampled as drained. With the check disabled, it is cleared down-gap + 2 edges after the current position was cleared.
- R8: If a power-up position is not fully in regulation within up-timeout + 1 edges of its requests rising, the sequence-error flag rises on that edge. That position is cleared on the next edge, and the cascade runs down from it without raising any higher position.
- R9: With the hard-trip bit at 0, a trip in the on phase starts the ordered cascade down: position 3 is cleared on the second edge while lower positions remain requested.
- R10: With the hard-trip bit at 1, a trip clears every channel request on the next edge, overriding software on commands, and the phase becomes off.
- R11: After a trip or a timeout the block stays off while the request pin remains high. Lowering the pin clears the sequence-error flag on the next edge and re-arms the block.
- R12: A software on or off bit changes only its own channel's request, on the next edge. An off bit wins over an on bit for the same channel in the same cycle.
- R13: The status word holds the requests in bits 3:0, the regulation flags in bits 7:4, the current position in bits 9:8 and the phase code in bits 12:10 (0 off, 1 up-arm, 2 up-wait, 3 up-gap, 4 on, 5 down-arm, 6 down-wait, 7 down-gap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Request pin: high starts power-up, low starts power-down |
| slot_sel | input | 8 | Position of each channel, 2 bits per channel |
| up_gap | input | 12 | Cycles between positions on power-up |
| dn_gap | input | 12 | Cycles between positions on power-down |
| up_tmo | input | 12 | Regulation timeout limit per power-up position |
| drain_wait | input | 1 | 1: a down position waits for its drained flags |
| trip_hard | input | 1 | 1: a trip clears all requests at once; 0: ordered cascade |
| trip | input | 1 | Filtered fault report |
| cmd_on | input | 4 | Per-channel software switch-on |
| cmd_off | input | 4 | Per-channel software switch-off |
| in_reg | input | 4 | Per-channel output-in-regulation flag |
| drained | input | 4 | Per-channel output-below-discharge-threshold flag |
| chan_req | output | 4 | Per-channel enable request to soft-start logic |
| seq_err | output | 1 | Power-up regulation timeout occurred |
| stat_word | output | 13 | Status word |

## Verification
Power-up is tried with one channel per position and with two channels sharing positions that are separated by empty ones. The first shows the exact gap timing, and the second shows that shared positions rise together and that empty ones are passed without the gap. Power-down is run once with the drain check on and once with it off, using drain lags long enough that the two timings differ by several cycles. Stuck regulation, a cascading trip and a hard trip each end a run. The three endings are told apart by which positions are still requested right after the event and by whether the block restarts while the pin stays high. Software commands, including an on and an off issued together, are applied in the off phase, where no cascade can mask them.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      PH_OFF     = 3'd0,
      PH_UP_ARM  = 3'd1,
      PH_UP_WAIT = 3'd2,
      PH_UP_GAP  = 3'd3,
      PH_ON      = 3'd4,
      PH_DN_ARM  = 3'd5,
      PH_DN_WAIT = 3'd6,
      PH_DN_GAP  = 3'd7
   } phase_t;
endpackage

// File: rtl/pwr_seq_counter.sv
module pwr_seq_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = '1;

   initial begin : chk_par
      assert (W >= 1) else $error("counter width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != MAXV)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwr_seq_slot_dec.sv
module pwr_seq_slot_dec #(
   parameter int N_CHAN = 4,
   parameter int N_SLOT = 4,
   localparam int SW = $clog2(N_SLOT)
) (
   input  logic [N_CHAN*SW-1:0] slot_sel,
   input  logic [SW-1:0]        cur,
   output logic [N_CHAN-1:0]    memb
);
   initial begin : chk_par
      assert (N_SLOT >= 2 && (1 << SW) == N_SLOT)
         else $error("position count must be a power of two, at least 2");
   end

   for (genvar i = 0; i < N_CHAN; i++) begin : g_ch
      assign memb[i] = (slot_sel[i*SW +: SW] == cur);
   end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int N_CHAN = 4,
   parameter int N_SLOT = 4,
   parameter int DLY_W  = 12,
   parameter int TMO_W  = 12,
   localparam int SW    = $clog2(N_SLOT),
   localparam int CW    = (DLY_W > TMO_W) ? DLY_W : TMO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_req,
   input  logic              trip,
   input  logic              trip_hard,
   input  logic              drain_wait,
   input  logic [DLY_W-1:0]  up_gap,
   input  logic [DLY_W-1:0]  dn_gap,
   input  logic [TMO_W-1:0]  up_tmo,
   input  logic [N_CHAN-1:0] memb,
   input  logic [N_CHAN-1:0] in_reg,
   input  logic [N_CHAN-1:0] drained,
   input  logic [CW-1:0]     cnt,
   output logic              cnt_clr,
   output logic              cnt_inc,
   output logic              slot_set,
   output logic              slot_clr,
   output logic              all_clr,
   output phase_t            phase,
   output logic [SW-1:0]     cur,
   output logic              seq_err
);
   localparam int CW1 = CW + 1;
   localparam logic [SW-1:0] TOP = SW'(N_SLOT - 1);

   phase_t        ph_n;
   logic [SW-1:0] cur_n;
   logic          lock;
   logic          err_set;
   logic          all_up, all_dn, empty, last, first, abort, hard;
   logic [CW1-1:0] cnt_p1, upg_w, dng_w, tmo_w;

   initial begin : chk_par
      assert (N_CHAN >= 1 && DLY_W >= 1 && TMO_W >= 1)
         else $error("channel count and widths must be positive");
   end

   assign all_up = ((in_reg & memb) == memb);
   assign all_dn = !drain_wait || ((drained & memb) == memb);
   assign empty  = (memb == '0);
   assign last   = (cur == TOP);
   assign first  = (cur == '0);
   assign hard   = trip && trip_hard;
   assign abort  = !pwr_req || trip;
   assign cnt_p1 = {1'b0, cnt} + 1'b1;
   assign upg_w  = CW1'(up_gap);
   assign dng_w  = CW1'(dn_gap);
   assign tmo_w  = CW1'(up_tmo);

   always_comb begin
      ph_n     = phase;
      cur_n    = cur;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      slot_set = 1'b0;
      slot_clr = 1'b0;
      all_clr  = 1'b0;
      err_set  = 1'b0;
      unique case (phase)
         PH_OFF: begin
            if (pwr_req && !lock && !trip) begin
               ph_n  = PH_UP_ARM;
               cur_n = '0;
            end
         end
         PH_UP_ARM: begin
            if (abort)
               ph_n = PH_DN_ARM;
            else if (empty) begin
               if (last) ph_n = PH_ON;
               else      cur_n = cur + 1'b1;
            end else begin
               slot_set = 1'b1;
               cnt_clr  = 1'b1;
               ph_n     = PH_UP_WAIT;
            end
         end
         PH_UP_WAIT: begin
            if (abort)
               ph_n = PH_DN_ARM;
            else if (all_up) begin
               if (last)
                  ph_n = PH_ON;
               else if (up_gap == '0) begin
                  ph_n  = PH_UP_ARM;
                  cur_n = cur + 1'b1;
               end else begin
                  ph_n    = PH_UP_GAP;
                  cnt_clr = 1'b1;
               end
            end else if ({1'b0, cnt} >= tmo_w) begin
               err_set = 1'b1;
               ph_n    = PH_DN_ARM;
            end else
               cnt_inc = 1'b1;
         end
         PH_UP_GAP: begin
            if (abort)
               ph_n = PH_DN_ARM;
            else if (cnt_p1 >= upg_w) begin
               ph_n  = PH_UP_ARM;
               cur_n = cur + 1'b1;
            end else
               cnt_inc = 1'b1;
         end
         PH_ON: begin
            if (abort) ph_n = PH_DN_ARM;
         end
         PH_DN_ARM: begin
            if (empty) begin
               if (first) ph_n = PH_OFF;
               else       cur_n = cur - 1'b1;
            end else begin
               slot_clr = 1'b1;
               cnt_clr  = 1'b1;
               ph_n     = PH_DN_WAIT;
            end
         end
         PH_DN_WAIT: begin
            if (all_dn) begin
               if (first)
                  ph_n = PH_OFF;
               else if (dn_gap == '0) begin
                  ph_n  = PH_DN_ARM;
                  cur_n = cur - 1'b1;
               end else begin
                  ph_n    = PH_DN_GAP;
                  cnt_clr = 1'b1;
               end
            end
         end
         PH_DN_GAP: begin
            if (cnt_p1 >= dng_w) begin
               ph_n  = PH_DN_ARM;
               cur_n = cur - 1'b1;
            end else
               cnt_inc = 1'b1;
         end
         default: ph_n = PH_OFF;
      endcase
      if (hard) begin
         ph_n     = PH_OFF;
         cur_n    = '0;
         slot_set = 1'b0;
         slot_clr = 1'b0;
         all_clr  = 1'b1;
         err_set  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OFF;
         cur     <= '0;
         lock    <= 1'b0;
         seq_err <= 1'b0;
      end else begin
         phase <= ph_n;
         cur   <= cur_n;
         if (trip || err_set)
            lock <= 1'b1;
         else if (!pwr_req)
            lock <= 1'b0;
         if (err_set)
            seq_err <= 1'b1;
         else if (!pwr_req)
            seq_err <= 1'b0;
      end
   end

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UP_WAIT && !all_up) |=> !(phase inside {PH_UP_GAP, PH_UP_ARM, PH_ON})); // R3
   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UP_ARM && $past(phase) == PH_UP_GAP) |-> (cur == SW'($past(cur) + 1'b1))); // R2
   AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DN_ARM && $past(phase) == PH_DN_GAP) |-> (cur == SW'($past(cur) - 1'b1))); // R6
   AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UP_WAIT && $stable(up_tmo)) |-> ({1'b0, cnt} <= tmo_w)); // R8
   AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && lock) |=> (phase == PH_OFF)); // R11
endmodule

// File: rtl/pwr_seq_chan_reg.sv
module pwr_seq_chan_reg #(
   parameter int N_CHAN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_set,
   input  logic              slot_clr,
   input  logic              all_clr,
   input  logic [N_CHAN-1:0] memb,
   input  logic [N_CHAN-1:0] cmd_on,
   input  logic [N_CHAN-1:0] cmd_off,
   output logic [N_CHAN-1:0] chan_req
);
   logic [N_CHAN-1:0] seq_v, nxt;

   always_comb begin
      seq_v = chan_req;
      if (slot_set) seq_v = seq_v | memb;
      if (slot_clr) seq_v = seq_v & ~memb;
      nxt = (seq_v | cmd_on) & ~cmd_off;
      if (all_clr) nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_req <= '0;
      else        chan_req <= nxt;
   end

   AST_HARD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      all_clr |=> (chan_req == '0)); // R10
   AST_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmd_off) && !all_clr) |=> ((chan_req & $past(cmd_off)) == '0)); // R12
   AST_CMD_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(cmd_on & ~cmd_off)) && !all_clr) |=> ((chan_req & $past(cmd_on & ~cmd_off)) == $past(cmd_on & ~cmd_off))); // R12
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int N_CHAN  = 4,
   parameter int N_SLOT  = 4,
   parameter int DLY_W   = 12,
   parameter int TMO_W   = 12,
   localparam int SW     = $clog2(N_SLOT),
   localparam int STAT_W = 2*N_CHAN + SW + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pwr_req,
   input  logic [N_CHAN*SW-1:0] slot_sel,
   input  logic [DLY_W-1:0]    up_gap,
   input  logic [DLY_W-1:0]    dn_gap,
   input  logic [TMO_W-1:0]    up_tmo,
   input  logic                drain_wait,
   input  logic                trip_hard,
   input  logic                trip,
   input  logic [N_CHAN-1:0]   cmd_on,
   input  logic [N_CHAN-1:0]   cmd_off,
   input  logic [N_CHAN-1:0]   in_reg,
   input  logic [N_CHAN-1:0]   drained,
   output logic [N_CHAN-1:0]   chan_req,
   output logic                seq_err,
   output logic [STAT_W-1:0]   stat_word
);
   localparam int CW = (DLY_W > TMO_W) ? DLY_W : TMO_W;

   logic [SW-1:0]     cur;
   logic [N_CHAN-1:0] memb;
   logic [CW-1:0]     cnt;
   logic              cnt_clr, cnt_inc, slot_set, slot_clr, all_clr;
   phase_t            phase;

   pwr_seq_slot_dec #(.N_CHAN(N_CHAN), .N_SLOT(N_SLOT)) u_dec (
      .slot_sel (slot_sel),
      .cur      (cur),
      .memb     (memb)
   );

   pwr_seq_counter #(.W(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt)
   );

   pwr_seq_fsm #(.N_CHAN(N_CHAN), .N_SLOT(N_SLOT), .DLY_W(DLY_W), .TMO_W(TMO_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_req    (pwr_req),
      .trip       (trip),
      .trip_hard  (trip_hard),
      .drain_wait (drain_wait),
      .up_gap     (up_gap),
      .dn_gap     (dn_gap),
      .up_tmo     (up_tmo),
      .memb       (memb),
      .in_reg     (in_reg),
      .drained    (drained),
      .cnt        (cnt),
      .cnt_clr    (cnt_clr),
      .cnt_inc    (cnt_inc),
      .slot_set   (slot_set),
      .slot_clr   (slot_clr),
      .all_clr    (all_clr),
      .phase      (phase),
      .cur        (cur),
      .seq_err    (seq_err)
   );

   pwr_seq_chan_reg #(.N_CHAN(N_CHAN)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_set (slot_set),
      .slot_clr (slot_clr),
      .all_clr  (all_clr),
      .memb     (memb),
      .cmd_on   (cmd_on),
      .cmd_off  (cmd_off),
      .chan_req (chan_req)
   );

   assign stat_word = {phase, cur, in_reg, chan_req};

   AST_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ON) |-> (cur == SW'(N_SLOT - 1))); // R5
endmodule

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
   localparam int CLK_T = 10;
   localparam int NC = 4;
   localparam int PL = 2*NC + 2;

   logic clk = 0, rst_n = 0;
   logic pwr_req = 0, drain_wait = 0, trip_hard = 0, trip = 0;
   logic [7:0] slot_sel = 8'b11_10_01_00;
   logic [11:0] up_gap = 0, dn_gap = 0, up_tmo = 12'd200;
   logic [3:0] cmd_on = 0, cmd_off = 0, in_reg = 0, drained = 4'hF, stuck = 0;
   logic [3:0] chan_req;
   logic seq_err;
   logic [12:0] stat_word;

   int ec = 0, total = 0, bad = 0;
   int rise_t[4], fall_t[4], pg_t[4], dr_t[4], cnt_m[4], lag[4];
   int dlag = 0;
   logic [3:0] req_q = 0;

   pwr_seq_top u_dut (.*);

   always #(CLK_T/2) clk = ~clk;
   always @(posedge clk) ec++;

   // regulator model
   always @(negedge clk) begin
      for (int i = 0; i < NC; i++) begin
         if (chan_req[i]) begin
            if (!req_q[i]) begin rise_t[i] = ec; cnt_m[i] = 0; drained[i] = 0; end
            if (!in_reg[i] && !stuck[i]) begin
               if (cnt_m[i] >= lag[i]) begin in_reg[i] = 1; pg_t[i] = ec; end
               else cnt_m[i]++;
            end
         end else begin
            if (req_q[i]) begin fall_t[i] = ec; cnt_m[i] = 0; in_reg[i] = 0; end
            if (!drained[i]) begin
               if (cnt_m[i] >= dlag) begin drained[i] = 1; dr_t[i] = ec; end
               else cnt_m[i]++;
            end
         end
         req_q[i] = chan_req[i];
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   function automatic int ph();
      return int'(stat_word[PL +: 3]);
   endfunction

   task automatic clr_rec();
      for (int i = 0; i < NC; i++) begin
         rise_t[i] = -1; fall_t[i] = -1; pg_t[i] = -1; dr_t[i] = -1;
      end
   endtask

   task automatic wait_ph(input int p, input string req);
      int n = 0;
      while (ph() != p && n < 2000) begin tick(); n++; end
      chk(req, ph(), p);
   endtask

   task automatic t_reset();
      chk("R1 requests", int'(chan_req), 0);
      chk("R1 phase", ph(), 0);
      chk("R1 seq_err", int'(seq_err), 0);
   endtask

   task automatic t_up(input int g);
      int n;
      slot_sel = 8'b11_10_01_00; up_gap = 12'(g);
      for (int i = 0; i < NC; i++) lag[i] = 2;
      clr_rec(); n = ec; pwr_req = 1;
      wait_ph(4, "R5 on phase");
      chk("R2 first position", rise_t[0], n + 2);
      for (int k = 1; k < NC; k++) chk("R3 gap after regulation", rise_t[k] - pg_t[k-1], g + 2);
      chk("R13 request bits", int'(stat_word[3:0]), 15);
      chk("R13 regulation bits", int'(stat_word[7:4]), 15);
      chk("R13 position bits", int'(stat_word[9:8]), 3);
   endtask

   task automatic t_down_nf();
      int n;
      drain_wait = 0; dn_gap = 12'd2; clr_rec(); n = ec; pwr_req = 0;
      wait_ph(0, "R6 off after cascade");
      chk("R6 top position first", fall_t[3], n + 2);
      for (int k = 2; k >= 0; k--) chk("R7 no-drain gap", fall_t[k] - fall_t[k+1], 4);
      chk("R6 all cleared", int'(chan_req), 0);
   endtask

   task automatic t_down_fl();
      drain_wait = 1; dn_gap = 12'd1; dlag = 3; clr_rec(); pwr_req = 0;
      wait_ph(0, "R6 off after drained cascade");
      for (int k = 2; k >= 0; k--) chk("R7 drain wait", fall_t[k] - dr_t[k+1], 3);
      dlag = 0; drain_wait = 0;
   endtask

   task automatic t_skip();
      int n;
      slot_sel = 8'b11_11_01_01; up_gap = 0;
      lag[0] = 1; lag[1] = 4; lag[2] = 1; lag[3] = 1;
      clr_rec(); n = ec; pwr_req = 1;
      wait_ph(4, "R5 on with empty positions");
      chk("R4 empty position 0 skipped", rise_t[0], n + 3);
      chk("R2 shared position together", rise_t[1], rise_t[0]);
      chk("R3 R4 wait slowest then skip", rise_t[2] - pg_t[1], 3);
      chk("R2 shared top position", rise_t[3], rise_t[2]);
      dn_gap = 0; pwr_req = 0;
      wait_ph(0, "R6 off");
   endtask

   task automatic t_timeout();
      int n, te;
      slot_sel = 8'b11_10_01_00; up_gap = 0; up_tmo = 12'd5; stuck = 4'b0010;
      for (int i = 0; i < NC; i++) lag[i] = 2;
      clr_rec(); pwr_req = 1; n = 0;
      while (!seq_err && n < 2000) begin tick(); n++; end
      te = ec;
      chk("R8 timeout edge", te - rise_t[1], 6);
      wait_ph(0, "R8 off after timeout");
      chk("R8 stuck position cleared", fall_t[1], te + 1);
      chk("R8 higher never raised", rise_t[2], -1);
      repeat (10) tick();
      chk("R11 stays off", ph(), 0);
      chk("R11 error held", int'(seq_err), 1);
      pwr_req = 0; tick();
      chk("R11 error cleared", int'(seq_err), 0);
      stuck = 0; up_tmo = 12'd200;
   endtask

   task automatic t_soft();
      int n;
      t_up(1);
      trip_hard = 0; dn_gap = 12'd2; clr_rec(); n = ec; trip = 1;
      tick(); trip = 0; tick();
      chk("R9 top position cleared", fall_t[3], n + 2);
      chk("R9 lower kept", int'(chan_req), 7);
      wait_ph(0, "R9 off");
      repeat (10) tick();
      chk("R11 no restart after trip", ph(), 0);
      pwr_req = 0; tick();
   endtask

   task automatic t_hard();
      t_up(0);
      trip_hard = 1; trip = 1; tick();
      chk("R10 all cleared", int'(chan_req), 0);
      chk("R10 phase off", ph(), 0);
      trip = 0; pwr_req = 0; tick();
   endtask

   task automatic t_cmd();
      cmd_on = 4'b0100; tick(); cmd_on = 0;
      chk("R12 single on", int'(chan_req), 4);
      cmd_on = 4'b0011; cmd_off = 4'b0010; tick(); cmd_on = 0; cmd_off = 0;
      chk("R12 off wins", int'(chan_req), 5);
      cmd_off = 4'b0100; tick(); cmd_off = 0;
      chk("R12 single off", int'(chan_req), 1);
      trip_hard = 1; trip = 1; cmd_on = 4'b1000; tick(); cmd_on = 0; trip = 0;
      chk("R10 hard trip beats on", int'(chan_req), 0);
      trip_hard = 0; tick();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) lag[i] = 2;
      clr_rec();
      repeat (3) tick();
      rst_n = 1; tick();
      t_reset();
      t_up(3);
      t_down_nf();
      t_up(2);
      t_down_fl();
      t_skip();
      t_timeout();
      t_soft();
      t_hard();
      t_cmd();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule